// File: doc/BRIEF.md
# Supply-Guarded Byte-Wide Static RAM

This block is a clocked model of a byte-wide static memory. It has 2048 locations of 8 bits, reached through 11 address lines, and is controlled by three active-low strobes: select, write and read-enable. The data port is split into a data-out bus and a drive-enable flag, so an enclosing pad ring can build a tri-state pin from them. The strobes are asynchronous to the clock. They pass through a two-stage synchronizer, and every cycle decision is taken on the synchronized copies.

A write is open while select and write are both low. It opens on whichever of the two falls last and closes on whichever rises first. The byte is committed to the array only when the cycle closes, using the data and address present in the last cycle that the write was still open. A read drives the addressed byte while select and read-enable are low and write is high. Pulling write low blanks the outputs.

Two digital supply flags come from an external monitor. `pwr_fail` reports that the supply is below the protection level, and `pwr_ok` reports that it is above the operating level. A fail flag locks the block out: writes are dropped, including any write still open, and the outputs stop driving. The lock holds until `pwr_ok` is seen, which gives the hysteresis band between the two flags. Neither reset nor lockout ever clears the stored bytes.

Top module: `pf_sram`

## Requirements
- R1: After reset the block is locked. `dout_en` is 0, `dout` is all zeros, and reads and writes are refused until `pwr_ok` has been sampled high.
- R2: With `wen_n` high and `sel_n`, `oen_n` low and the block unlocked, `dout_en` is 1 and `dout` carries the byte stored at `addr`. The response appears on the third rising clock edge after the strobes change (two synchronizer stages plus one output register).
- R3: A write opens at the later falling edge of `sel_n`/`wen_n` and closes at the earlier rising edge. Either order of opening or closing writes the byte. The byte stored is the `din` value present while the cycle was still open just before it closed. Later changes to `din` have no effect.
- R4: `wen_n` low alone, `sel_n` low alone, or the two lows not overlapping in time, store nothing.
- R5: `wen_n` low forces `dout_en` to 0 even while `sel_n` and `oen_n` are low. Reading resumes when `wen_n` returns high.
- R6: `pwr_fail` high sets lockout at the next clock edge. Under lockout `dout_en` is 0 and no byte is written.
- R7: Lockout is released only by `pwr_ok` high. `pwr_fail` falling with `pwr_ok` still low keeps the block locked. If both flags are high, the fail flag wins.
- R8: A write that is open when lockout asserts is discarded, and the addressed byte keeps its old value.
- R9: A write held open across the release of lockout does not commit. A new write needs a fresh opening edge seen while the block is unlocked.
- R10: Reset and lockout leave every stored byte unchanged.
- R11: A write changes only the addressed byte. Every other location keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of control state |
| sel_n | input | 1 | Active-low chip select (asynchronous) |
| wen_n | input | 1 | Active-low write strobe (asynchronous) |
| oen_n | input | 1 | Active-low read/output enable (asynchronous) |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, all zeros when not driving |
| dout_en | output | 1 | Drive enable for the data pins |
| pwr_ok | input | 1 | Supply above operating level |
| pwr_fail | input | 1 | Supply below protection level |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8. The array is then only 16 bytes, so a random series of writes lands on every location several times, and a full read sweep after each phase checks every byte for accidental changes in a few hundred cycles. The narrow address keeps the whole lockout and reset sequences short, including writes held open across a lockout. The synchronizer depth stays at its default of two, which fixes the three-edge read latency that both the bench and the checker rely on.

// File: rtl/pf_sram_pkg.sv
package pf_sram_pkg;

    // Strobes after synchronization, converted to active-high
    typedef struct packed {
        logic sel;
        logic wen;
        logic oen;
    } bus_ctl_t;

    typedef enum logic [0:0] {
        WS_IDLE = 1'b0,
        WS_OPEN = 1'b1
    } wr_state_e;

    localparam int unsigned CTL_W = 3;

    // raw_n packs {sel_n, wen_n, oen_n}
    function automatic bus_ctl_t decode_ctl(input logic [CTL_W-1:0] raw_n);
        bus_ctl_t c;
        c.sel = ~raw_n[2];
        c.wen = ~raw_n[1];
        c.oen = ~raw_n[0];
        return c;
    endfunction

    function automatic logic is_read(input bus_ctl_t c);
        return c.sel & c.oen & ~c.wen;
    endfunction

    function automatic logic is_write(input bus_ctl_t c);
        return c.sel & c.wen;
    endfunction

endpackage

// File: rtl/pf_sram_sync.sv
module pf_sram_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pf_sram_supply.sv
module pf_sram_supply (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic pwr_fail,
    output logic locked
);
    // Set on fail, clear only on ok: hysteresis between the two levels
    always_ff @(posedge clk) begin
        if (rst)           locked <= 1'b1;
        else if (pwr_fail) locked <= 1'b1;
        else if (pwr_ok)   locked <= 1'b0;
    end
endmodule

// File: rtl/pf_sram_wrctl.sv
module pf_sram_wrctl
    import pf_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_act,
    input  logic              locked,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    wr_state_e         state_q;
    logic              act_d;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic              open_edge;

    // A cycle opens only on a transition into the both-low condition
    assign open_edge = wr_act & ~act_d & ~locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= WS_IDLE;
            act_d     <= 1'b1;
            hold_addr <= '0;
            hold_data <= '0;
        end else begin
            act_d <= wr_act;
            if (locked) begin
                state_q <= WS_IDLE;
            end else begin
                unique case (state_q)
                    WS_IDLE: begin
                        if (open_edge) begin
                            state_q   <= WS_OPEN;
                            hold_addr <= addr;
                            hold_data <= din;
                        end
                    end
                    WS_OPEN: begin
                        if (wr_act) begin
                            hold_addr <= addr;
                            hold_data <= din;
                        end else begin
                            state_q <= WS_IDLE;
                        end
                    end
                    default: state_q <= WS_IDLE;
                endcase
            end
        end
    end

    assign mem_we   = (state_q == WS_OPEN) & ~wr_act & ~locked;
    assign mem_addr = hold_addr;
    assign mem_data = hold_data;
endmodule

// File: rtl/pf_sram_array.sv
module pf_sram_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    // No reset: contents persist across reset and lockout
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pf_sram_rdport.sv
module pf_sram_rdport #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_act,
    input  logic              locked,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    always_ff @(posedge clk) begin
        if (rst || locked || !rd_act) begin
            dout_en <= 1'b0;
            dout    <= '0;
        end else begin
            dout_en <= 1'b1;
            dout    <= rdata;
        end
    end
endmodule

// File: rtl/pf_sram.sv
module pf_sram
    import pf_sram_pkg::*;
#(
    parameter int unsigned ADDR_W      = 11,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wen_n,
    input  logic              oen_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    input  logic              pwr_ok,
    input  logic              pwr_fail
);
    logic [CTL_W-1:0]  raw_s;
    bus_ctl_t          ctl;
    logic              locked;
    logic              wr_act;
    logic              rd_act;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic [DATA_W-1:0] rdata;

    pf_sram_sync #(
        .WIDTH  (CTL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({sel_n, wen_n, oen_n}),
        .q  (raw_s)
    );

    assign ctl    = decode_ctl(raw_s);
    assign wr_act = is_write(ctl);
    assign rd_act = is_read(ctl);

    pf_sram_supply u_supply (
        .clk     (clk),
        .rst     (rst),
        .pwr_ok  (pwr_ok),
        .pwr_fail(pwr_fail),
        .locked  (locked)
    );

    pf_sram_wrctl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_wrctl (
        .clk     (clk),
        .rst     (rst),
        .wr_act  (wr_act),
        .locked  (locked),
        .addr    (addr),
        .din     (din),
        .mem_we  (mem_we),
        .mem_addr(mem_addr),
        .mem_data(mem_data)
    );

    pf_sram_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_addr),
        .wdata(mem_data),
        .raddr(addr),
        .rdata(rdata)
    );

    pf_sram_rdport #(
        .DATA_W(DATA_W)
    ) u_rdport (
        .clk    (clk),
        .rst    (rst),
        .rd_act (rd_act),
        .locked (locked),
        .rdata  (rdata),
        .dout   (dout),
        .dout_en(dout_en)
    );
endmodule

// File: rtl/pf_sram_chk.sv
module pf_sram_chk #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              wen_n,
    input logic              oen_n,
    input logic              pwr_fail,
    input logic              mem_we,
    input logic              dout_en,
    input logic [DATA_W-1:0] dout
);
    // R1: the cycle after reset, outputs are quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!dout_en && dout == '0));

    // R6: a fail flag silences the outputs two edges later
    a_r6_fail_silences: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |-> ##2 !dout_en);

    // R6: no array write in the cycle after a fail flag was seen
    a_r6_no_commit_locked: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !$past(pwr_fail));

    // Latency-dependent checks, written for the two-stage synchronizer
    if (SYNC_STAGES == 2) begin : g_lat
        // R5: write strobe low blanks the outputs
        a_r5_wen_blanks: assert property (@(posedge clk) disable iff (rst)
            !$past(wen_n, 3) |-> !dout_en);

        // R2: driving implies a proper read strobe pattern
        a_r2_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
            dout_en |-> (!$past(sel_n, 3) && !$past(oen_n, 3) && $past(wen_n, 3)));
    end
endmodule

bind pf_sram pf_sram_chk #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_n   (sel_n),
    .wen_n   (wen_n),
    .oen_n   (oen_n),
    .pwr_fail(pwr_fail),
    .mem_we  (mem_we),
    .dout_en (dout_en),
    .dout    (dout)
);

// File: tb/tb_pf_sram.sv
module tb_pf_sram;
    localparam int unsigned AW = 4;
    localparam int unsigned DW = 8;
    localparam int unsigned NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1, wen_n = 1'b1, oen_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic          pwr_ok = 1'b0, pwr_fail = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [DW-1:0] model [NB];

    always #2.5 clk = ~clk;

    pf_sram #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wen_n(wen_n), .oen_n(oen_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .pwr_ok(pwr_ok), .pwr_fail(pwr_fail)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung actual=%0d cycles expected=completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [DW-1:0] exp_byte(input logic [AW-1:0] a);
        return model[a];
    endfunction

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // open_ord 0: select first; close_ord 0: write strobe rises first
    task automatic wr_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit open_ord, input bit close_ord, input bit commits);
        addr = a; din = d;
        waitn(2);
        if (!open_ord) begin sel_n = 1'b0; waitn(3); wen_n = 1'b0; end
        else           begin wen_n = 1'b0; waitn(3); sel_n = 1'b0; end
        waitn(4);
        if (!close_ord) begin wen_n = 1'b1; waitn(3); sel_n = 1'b1; end
        else            begin sel_n = 1'b1; waitn(3); wen_n = 1'b1; end
        waitn(4);
        if (commits) model[a] = d;
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input string tag);
        addr = a; wen_n = 1'b1; sel_n = 1'b0; oen_n = 1'b0;
        waitn(5);
        check(dout_en === 1'b1 && dout === exp_byte(a), tag,
              {7'd0, dout_en, dout}, {8'h01, exp_byte(a)});
        sel_n = 1'b1; oen_n = 1'b1;
        waitn(3);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < NB; i++) rd_check(AW'(i), tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        waitn(4);
        rst = 1'b0;
        waitn(2);

        // R1: locked after reset until pwr_ok
        addr = 4'd1; sel_n = 1'b0; oen_n = 1'b0;
        waitn(5);
        check(dout_en === 1'b0 && dout === '0, "R1 locked after reset",
              {7'd0, dout_en, dout}, 16'h0000);
        sel_n = 1'b1; oen_n = 1'b1;
        wr_cycle(4'd1, 8'hE7, 1'b0, 1'b0, 1'b0);
        pwr_ok = 1'b1;
        waitn(3);

        // R3 / R11: fill every byte with mixed open/close orders
        for (int i = 0; i < NB; i++)
            wr_cycle(AW'(i), DW'(i * 29 + 8'h3C), 1'(i), 1'(i >> 1), 1'b1);
        sweep("R3 fill and read back");

        // R3: data changed mid-cycle, the last open value wins
        addr = 4'd2; din = 8'hA1; sel_n = 1'b0; wen_n = 1'b0;
        waitn(4); din = 8'hB2; waitn(4);
        wen_n = 1'b1; waitn(3); din = 8'hC3; waitn(2); sel_n = 1'b1; waitn(3);
        model[2] = 8'hB2;
        rd_check(4'd2, "R3 commit at closing edge");

        // R4: strobes alone or without overlap store nothing
        addr = 4'd7; din = 8'hEE;
        wen_n = 1'b0; waitn(5); wen_n = 1'b1; waitn(3);
        sel_n = 1'b0; waitn(5); sel_n = 1'b1; waitn(1);
        wen_n = 1'b0; waitn(5); wen_n = 1'b1; waitn(3);
        rd_check(4'd7, "R4 no overlap no write");

        // R5: write strobe blanks an active read
        addr = 4'd7; din = model[7]; sel_n = 1'b0; oen_n = 1'b0;
        waitn(5);
        check(dout_en === 1'b1, "R5 read before blank", {15'd0, dout_en}, 16'h1);
        wen_n = 1'b0; waitn(5);
        check(dout_en === 1'b0, "R5 wen_n low blanks output", {15'd0, dout_en}, 16'h0);
        wen_n = 1'b1; waitn(5);
        check(dout_en === 1'b1 && dout === exp_byte(4'd7), "R5 read resumes",
              {7'd0, dout_en, dout}, {8'h01, exp_byte(4'd7)});
        sel_n = 1'b1; oen_n = 1'b1; waitn(3);

        // R6 / R7: lockout blocks access, hysteresis holds it
        pwr_ok = 1'b0; pwr_fail = 1'b1; waitn(3);
        wr_cycle(4'd3, 8'h22, 1'b0, 1'b1, 1'b0);
        addr = 4'd3; sel_n = 1'b0; oen_n = 1'b0; waitn(5);
        check(dout_en === 1'b0, "R6 locked no drive", {15'd0, dout_en}, 16'h0);
        pwr_fail = 1'b0; waitn(5);
        check(dout_en === 1'b0, "R7 still locked without pwr_ok", {15'd0, dout_en}, 16'h0);
        pwr_ok = 1'b1; pwr_fail = 1'b1; waitn(5);
        check(dout_en === 1'b0, "R7 fail wins over ok", {15'd0, dout_en}, 16'h0);
        pwr_fail = 1'b0; waitn(5);
        check(dout_en === 1'b1 && dout === exp_byte(4'd3), "R6 write ignored under lock",
              {7'd0, dout_en, dout}, {8'h01, exp_byte(4'd3)});
        sel_n = 1'b1; oen_n = 1'b1; waitn(3);

        // R8: open write dropped when lockout asserts
        addr = 4'd5; din = 8'h33; sel_n = 1'b0; wen_n = 1'b0; waitn(4);
        pwr_ok = 1'b0; pwr_fail = 1'b1; waitn(3);
        wen_n = 1'b1; sel_n = 1'b1; waitn(4);
        pwr_fail = 1'b0; pwr_ok = 1'b1; waitn(3);
        rd_check(4'd5, "R8 open write discarded");

        // R9: write held across release does not commit
        pwr_ok = 1'b0; pwr_fail = 1'b1; waitn(3);
        addr = 4'd6; din = 8'h66; sel_n = 1'b0; wen_n = 1'b0; waitn(4);
        pwr_fail = 1'b0; pwr_ok = 1'b1; waitn(5);
        wen_n = 1'b1; waitn(2); sel_n = 1'b1; waitn(4);
        rd_check(4'd6, "R9 no commit without fresh edge");

        // R11: random writes, then full sweep
        for (int n = 0; n < 60; n++) begin
            logic [AW-1:0] ra;
            logic [DW-1:0] rd;
            ra = AW'($urandom % NB);
            rd = DW'($urandom);
            wr_cycle(ra, rd, 1'($urandom), 1'($urandom), 1'b1);
            if (n % 15 == 14) rd_check(ra, "R11 random write readback");
        end
        sweep("R11 other bytes intact");

        // R10: reset and lockout keep contents
        rst = 1'b1; waitn(3); rst = 1'b0; waitn(3);
        sweep("R10 contents after reset");
        pwr_ok = 1'b0; pwr_fail = 1'b1; waitn(4);
        pwr_fail = 1'b0; pwr_ok = 1'b1; waitn(3);
        sweep("R10 contents after lockout");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule